// File: doc/BRIEF.md
# Instruction Context Propagation Queue

This block sits beside an instruction decoder. It tells the decoder, for each 32-bit instruction as it issues, which stored 24-bit prefix context applies, if any. It holds two things. The first is a queue of 40 small slot indices, one slot per upcoming instruction. The second is a table of seven bindable context words. Index zero in a slot means the instruction runs with no prefix. Indices one to seven name one of the stored context words.

A propagation command carries three fields: a 24-bit context word, the index to bind it to, and a 21-bit placement mask. An accepted command rebinds the context word. It also writes the index into the slots chosen by the mask, starting just above the highest slot that is already occupied. Each issue strobe retires the bottom slot, shifts the queue one slot toward the bottom, and reports the retired index and its context word on the following cycle.

A command is refused and raises a one-cycle exception in three cases: the placement would run past the last slot, the reserved mask bit is set, or the command tries to bind index zero. A refused command changes nothing. A synchronous clear empties the queue and forgets every binding.

Top module: `ctx_prop_queue`

## Requirements
- R1: After reset the queue is empty: out_valid_o, out_idx_o and exc_o are 0, and 40 issue strobes each report index 0 with out_valid_o low.
- R2: The cycle after issue_i is high, out_idx_o shows the index that was in slot 0. The queue then moves down by one slot, and the top slot (39) is filled with 0. In a cycle after issue_i was low, out_idx_o is 0 and out_valid_o is low.
- R3: The cycle after an issue, out_valid_o is high exactly when the retired index is nonzero, and out_ctx_o then equals the 24-bit word most recently bound to that index. Index 0 means no prefix.
- R4: An accepted command binds cmd_ctx_i to cmd_idx_i, replacing any earlier word for that index. For each set bit i of cmd_mask_i[19:0], it writes cmd_idx_i into slot base+i, where base is one above the highest nonzero slot (0 when the queue is empty). Existing slots and the gaps left by clear mask bits are not changed.
- R5: If base plus the position of the highest set bit of cmd_mask_i[19:0] exceeds 39, exc_o pulses high the cycle after the command, and neither the queue nor the bindings change.
- R6: A command with cmd_mask_i[20] set, or with cmd_idx_i equal to 0, raises exc_o the next cycle and changes nothing.
- R7: When issue_i and cmd_valid_i are high in the same cycle, the shift is applied first. Both the insert point and the overrun test use the shifted queue.
- R8: clr_i empties the queue and drops all bindings. It takes priority over an issue or a command in the same cycle, and the next cycle shows out_valid_o, out_idx_o and exc_o at 0.
- R9: exc_o is high for one cycle only, and only after a cycle that carried a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of queue and bindings |
| issue_i | input | 1 | One instruction issues; retire slot 0 |
| cmd_valid_i | input | 1 | Propagation command present |
| cmd_ctx_i | input | 24 | Context word to bind |
| cmd_idx_i | input | 3 | Index the word is bound to (1..7) |
| cmd_mask_i | input | 21 | Bits 0..19 select slots base+i; bit 20 reserved, must be 0 |
| out_valid_o | output | 1 | Retired instruction carries a prefix |
| out_idx_o | output | 3 | Retired index |
| out_ctx_o | output | 24 | Context word of the retired index, valid when out_valid_o |
| exc_o | output | 1 | Command refused (one-cycle pulse) |

## Verification
An issue shift and a command insert can land in the same cycle. When they do, the insert point must come from the queue as it stands after the shift, and a placement that only fits because the shift freed the top slot must be accepted. A near-exhaustive stream provokes this: it fills the queue to exact boundaries and then issues and inserts together. A long pseudo-random mix of issue, command and clear is also driven. Each outcome is judged against an arithmetic model of the slots and bindings, slot by slot, by draining the queue through the issue output.

// File: rtl/ctxq_pkg.sv
package ctxq_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_RSVD = 2'd1,
    FLT_IDX0 = 2'd2,
    FLT_OVR  = 2'd3
  } fault_e;

  function automatic fault_e classify(input logic rsvd, input logic idx_zero,
                                      input logic ovr);
    if (rsvd)          return FLT_RSVD;
    else if (idx_zero) return FLT_IDX0;
    else if (ovr)      return FLT_OVR;
    else               return FLT_NONE;
  endfunction
endpackage

// File: rtl/ctxq_slots.sv
module ctxq_slots #(
  parameter int SLOTS = 40,
  parameter int IDX_W = 3,
  parameter int SPAN  = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic                   issue_i,
  input  logic                   ins_i,
  input  logic [SPAN-1:0]        ins_mask_i,
  input  logic [IDX_W-1:0]       ins_idx_i,
  output logic [IDX_W-1:0]       head_o,
  output logic [SLOTS*IDX_W-1:0] q_o,
  output logic                   ovr_o
);
  localparam int QW = SLOTS * IDX_W;
  localparam int PW = $clog2(SLOTS + 1);
  localparam int OW = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic [QW-1:0] q_r, q_sh, q_nx;
  logic [PW-1:0] base;
  logic [OW-1:0] last;
  logic          any;

  // shift happens before the insert point is searched
  assign q_sh = issue_i ? (q_r >> IDX_W) : q_r;

  always_comb begin
    base = '0;
    for (int s = 0; s < SLOTS; s++)
      if (q_sh[s*IDX_W +: IDX_W] != '0) base = PW'(s + 1);
  end

  always_comb begin
    last = '0;
    any  = 1'b0;
    for (int i = 0; i < SPAN; i++)
      if (ins_mask_i[i]) begin
        last = OW'(i);
        any  = 1'b1;
      end
  end

  assign ovr_o = any && ((int'(base) + int'(last)) > (SLOTS - 1));

  always_comb begin
    q_nx = q_sh;
    for (int s = 0; s < SLOTS; s++) begin
      int off;
      off = s - int'(base);
      if (ins_i && off >= 0 && off < SPAN)
        if (ins_mask_i[OW'(off)]) q_nx[s*IDX_W +: IDX_W] = ins_idx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) q_r <= '0;
    else              q_r <= q_nx;
  end

  assign head_o = q_r[IDX_W-1:0];
  assign q_o    = q_r;
endmodule

// File: rtl/ctxq_store.sv
module ctxq_store #(
  parameter int IDX_W = 3,
  parameter int CTX_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      waddr_i,
  input  logic [CTX_W-1:0]      wdata_i,
  input  logic                  re_i,
  input  logic [IDX_W-1:0]      raddr_i,
  output logic [CTX_W-1:0]      rdata_o,
  output logic [(1<<IDX_W)-1:0] vld_o
);
  localparam int N = 1 << IDX_W;

  logic [CTX_W-1:0] mem [N];
  logic [N-1:0]     vld;

  // plain write port, no reset: maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // registered read, old data on a same-cycle write
  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) vld <= '0;
    else if (we_i)    vld[waddr_i] <= 1'b1;
  end

  assign vld_o = vld;
endmodule

// File: rtl/ctx_prop_queue.sv
module ctx_prop_queue
  import ctxq_pkg::*;
#(
  parameter int SLOTS  = 40,
  parameter int IDX_W  = 3,
  parameter int CTX_W  = 24,
  parameter int MASK_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic              cmd_valid_i,
  input  logic [CTX_W-1:0]  cmd_ctx_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [MASK_W-1:0] cmd_mask_i,
  output logic              out_valid_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [CTX_W-1:0]  out_ctx_o,
  output logic              exc_o
);
  localparam int SPAN = MASK_W - 1;
  localparam int N    = 1 << IDX_W;

  logic [IDX_W-1:0]       head;
  logic [SLOTS*IDX_W-1:0] q_all;
  logic                   ovr;
  logic [N-1:0]           vld;
  fault_e                 fault;
  logic                   ins;

  assign fault = classify(cmd_mask_i[MASK_W-1], cmd_idx_i == '0, ovr);
  assign ins   = cmd_valid_i && !clr_i && (fault == FLT_NONE);

  ctxq_slots #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SPAN(SPAN)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .issue_i    (issue_i),
    .ins_i      (ins),
    .ins_mask_i (cmd_mask_i[SPAN-1:0]),
    .ins_idx_i  (cmd_idx_i),
    .head_o     (head),
    .q_o        (q_all),
    .ovr_o      (ovr)
  );

  ctxq_store #(.IDX_W(IDX_W), .CTX_W(CTX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .we_i    (ins),
    .waddr_i (cmd_idx_i),
    .wdata_i (cmd_ctx_i),
    .re_i    (issue_i),
    .raddr_i (head),
    .rdata_o (out_ctx_o),
    .vld_o   (vld)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      exc_o       <= 1'b0;
    end else begin
      out_valid_o <= issue_i && (head != '0) && vld[head];
      out_idx_o   <= issue_i ? head : '0;
      exc_o       <= cmd_valid_i && (fault != FLT_NONE);
    end
  end
endmodule

// File: rtl/ctxq_chk.sv
module ctxq_chk #(
  parameter int SLOTS  = 40,
  parameter int IDX_W  = 3,
  parameter int MASK_W = 21
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr_i,
  input logic                   issue_i,
  input logic                   cmd_valid_i,
  input logic [IDX_W-1:0]       cmd_idx_i,
  input logic [MASK_W-1:0]      cmd_mask_i,
  input logic                   out_valid_o,
  input logic [IDX_W-1:0]       out_idx_o,
  input logic                   exc_o,
  input logic [SLOTS*IDX_W-1:0] q
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid_o && !exc_o && out_idx_o == '0)); // R1

  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> (!out_valid_o && out_idx_o == '0)); // R2

  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !cmd_valid_i && !clr_i) |=> (q == ($past(q) >> IDX_W))); // R2

  AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_idx_o != '0)); // R3

  AST_REFUSED_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !issue_i && !clr_i) |=> (!exc_o || q == $past(q))); // R5

  AST_RESERVED_BIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !clr_i && cmd_mask_i[MASK_W-1]) |=> exc_o); // R6

  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !clr_i && cmd_idx_i == '0) |=> exc_o); // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q == '0 && !out_valid_o && !exc_o)); // R8

  AST_EXC_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_i |=> !exc_o); // R9
endmodule

bind ctx_prop_queue ctxq_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_i       (clr_i),
  .issue_i     (issue_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_idx_i   (cmd_idx_i),
  .cmd_mask_i  (cmd_mask_i),
  .out_valid_o (out_valid_o),
  .out_idx_o   (out_idx_o),
  .exc_o       (exc_o),
  .q           (q_all)
);

// File: tb/ctx_prop_queue_test.sv
`timescale 1ns/1ps
module ctx_prop_queue_test;
  localparam int SLOTS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0;
  logic        issue_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [23:0] cmd_ctx_i = '0;
  logic [2:0]  cmd_idx_i = '0;
  logic [20:0] cmd_mask_i = '0;
  logic        out_valid_o;
  logic [2:0]  out_idx_o;
  logic [23:0] out_ctx_o;
  logic        exc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int          mq [SLOTS];
  logic [23:0] mctx [8];
  bit          mv [8];
  logic [31:0] lf = 32'h1234_5678;

  always #5 clk = ~clk;

  ctx_prop_queue uut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .issue_i(issue_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ctx_i(cmd_ctx_i), .cmd_idx_i(cmd_idx_i),
    .cmd_mask_i(cmd_mask_i), .out_valid_o(out_valid_o), .out_idx_o(out_idx_o),
    .out_ctx_o(out_ctx_o), .exc_o(exc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  // one cycle: drive, model, wait past the edge, compare
  task automatic step(input bit c, input bit iss, input bit cv,
                      input logic [23:0] cx, input int ix, input logic [20:0] m);
    int e_idx = 0;
    bit e_val = 0;
    bit e_exc = 0;
    logic [23:0] e_ctx = '0;
    string xreq = "R9";
    clr_i = c; issue_i = iss; cmd_valid_i = cv;
    cmd_ctx_i = cx; cmd_idx_i = 3'(ix); cmd_mask_i = m;
    if (c) begin
      foreach (mq[s]) mq[s] = 0;
      foreach (mv[k]) mv[k] = 0;
      xreq = "R8";
    end else begin
      if (iss) begin
        e_idx = mq[0];
        e_val = (mq[0] != 0) && mv[mq[0]];
        e_ctx = mctx[mq[0]];
        for (int s = 0; s < SLOTS - 1; s++) mq[s] = mq[s+1];
        mq[SLOTS-1] = 0;
      end
      if (cv) begin
        int b = 0;
        int last = -1;
        bit ovr;
        for (int s = 0; s < SLOTS; s++) if (mq[s] != 0) b = s + 1;
        for (int i = 0; i < 20; i++) if (m[i]) last = i;
        ovr = (last >= 0) && (b + last > SLOTS - 1);
        e_exc = m[20] || ix == 0 || ovr;
        if (m[20] || ix == 0) xreq = "R6";
        else if (ovr)         xreq = "R5";
        else                  xreq = iss ? "R7" : "R4";
        if (!e_exc) begin
          mctx[ix] = cx;
          mv[ix] = 1;
          for (int i = 0; i < 20; i++) if (m[i]) mq[b+i] = ix;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(out_idx_o == 3'(e_idx), c ? "R8 idx" : "R2 idx", int'(out_idx_o), e_idx);
    chk(out_valid_o == e_val, c ? "R8 valid" : "R3 valid", int'(out_valid_o), int'(e_val));
    if (e_val) chk(out_ctx_o == e_ctx, "R3 ctx", int'(out_ctx_o), int'(e_ctx));
    chk(exc_o == e_exc, xreq, int'(exc_o), int'(e_exc));
    clr_i = 0; issue_i = 0; cmd_valid_i = 0;
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) step(0, 1, 0, '0, 0, '0);
  endtask

  task automatic ins(input int ix, input logic [20:0] m, input logic [23:0] cx);
    step(0, 0, 1, cx, ix, m);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (mq[s]) mq[s] = 0;
    foreach (mv[k]) begin mv[k] = 0; mctx[k] = '0; end
    repeat (2) @(posedge clk);
    #1 rst = 0;
    chk(!out_valid_o && out_idx_o == 0 && !exc_o, "R1 reset", int'(out_valid_o), 0);
    drain(SLOTS); // R1 empty queue

    // R4 basic placement with gaps, then append above the highest slot
    ins(1, 21'b101, 24'hA0A0A0);
    ins(2, 21'b1, 24'hB1B1B1);
    drain(6);

    // R4 sweep: every index with several masks, plus rebinding
    for (int ix = 1; ix < 8; ix++)
      for (int p = 0; p < 5; p++) begin
        logic [20:0] m;
        case (p)
          0: m = 21'h1;
          1: m = 21'h80000;
          2: m = 21'h5555 << (ix % 3);
          3: m = 21'(32'hFFFFF >> ix);
          default: m = 21'(ix * 37 + 3);
        endcase
        ins(ix, m, 24'(ix * 24'h010203 + p));
        ins((ix % 7) + 1, 21'h3, 24'(24'hF00000 + ix));
        drain(SLOTS);
      end

    // R5 overrun boundaries
    ins(3, 21'hFFFFF, 24'h333333);     // slots 0..19
    ins(4, 21'hFFFFF, 24'h444444);     // slots 20..39, exact fit
    ins(5, 21'h1, 24'h555555);         // base 40: overrun
    ins(5, 21'h0, 24'h565656);         // empty mask: no overrun
    // R7 shift frees slot 39, same-cycle insert fits
    step(0, 1, 1, 24'h777777, 6, 21'h1);
    drain(SLOTS);
    ins(2, 21'h80000, 24'h222222);     // slot 19
    ins(2, 21'h40000, 24'h232323);     // base 20, bit 18 -> 38
    ins(2, 21'h4, 24'h242424);         // base 39, bit 2 -> 41 overrun
    step(0, 1, 1, 24'h252525, 1, 21'h4); // shifted base 38, 40: overrun R7/R5
    drain(SLOTS);

    // R6 reserved bit and zero index
    ins(1, 21'h100001, 24'h111111);
    ins(0, 21'h1, 24'h000111);
    drain(3);

    // R8 clear beats command and issue
    ins(7, 21'hFF, 24'h7F7F7F);
    step(1, 1, 1, 24'h123456, 3, 21'h1);
    drain(10);

    // R7 mixed stream, all functions interleaved
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r = rnd();
      logic [31:0] r2 = rnd();
      bit c = (r[5:0] == 0);
      bit iss = r[6] | r[7];
      bit cv = (r[9:8] == 0);
      int ix = (r[12:10] == 0 && r[13]) ? 0 : int'(r[12:10] == 0 ? 3'd1 : r[12:10]);
      logic [20:0] m = {r2[31:27] == 0, 20'(r2[19:0] >> r2[24:20])};
      step(c, iss, cv, r2[23:0] ^ 24'(n), ix, m);
    end
    drain(SLOTS);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule